// File: doc/BRIEF.md
# Register Window Pointer Controller

This block tracks which register window of a windowed integer register file is current, and judges every window move against a per-window invalid mask. A move that would step into a window marked invalid is refused: the pointer holds and a trap flag rises in the same cycle, so the pipeline can divert to the trap handler. Accepted moves update the pointer at the next clock edge. The block also gives the register-file port steering the window to read sources from (the old window) and the window to write the destination into (the new window).

The pointer counts down on a save and on trap entry, and counts up on a restore or a return from trap. It wraps at a configured window count between 2 and the parameter `NWIN`. Trap entry always moves down and never consults the mask. A mask write is held in a short pending pipeline before it governs moves, so a write does not affect the three instructions that follow it. The block treats each clock as one instruction slot. All pins are plain control and status with no handshake: a request is acted on in the cycle it is high.

Top module: `wpc_ctrl`

## Requirements
- R1: After reset the pointer is 0 and the mask is all zeros, so no move raises a trap flag.
- R2: A save moves the pointer to (pointer - 1) modulo the window count at the next edge; in the request cycle `src_win` shows the old pointer and `dst_win` and `next_cwp` show the target.
- R3: A save whose target window has its mask bit set raises `ovf_trap` in that cycle and the pointer keeps its value.
- R4: A restore or a return from trap moves the pointer to (pointer + 1) modulo the window count at the next edge.
- R5: A restore or a return from trap whose target window has its mask bit set raises `unf_trap` in that cycle and the pointer keeps its value.
- R6: A mask write in cycle W has no effect on moves in cycles W+1, W+2 and W+3; moves from cycle W+4 on use the written value.
- R7: When a mask write takes effect, bits at or above the window count in force at that moment are stored as zero and stay zero if the count is raised later.
- R8: Trap entry moves the pointer down by one modulo the window count without checking the mask, raises no trap flag and takes priority over any move request in the same cycle.
- R9: The pointer wraps: a save from 0 goes to count - 1 and a restore from count - 1 goes to 0; a `win_count` below 2 acts as 2 and one above `NWIN` acts as `NWIN`.
- R10: When several move requests are high together, save wins over restore and return from trap; at most one trap flag is high.
- R11: With no request high, the pointer holds, both flags are low and `src_win`, `dst_win` and `next_cwp` all equal the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| rett_req | input | 1 | Return from trap: move to the next higher window |
| trap_enter | input | 1 | Trap taken: move down without a mask check |
| mask_wr | input | 1 | Write the invalid mask (delayed) |
| mask_wdata | input | NWIN | New invalid mask, bit i marks window i |
| win_count | input | clog2(NWIN+1) | Number of windows in use |
| cwp | output | clog2(NWIN) | Current window pointer |
| next_cwp | output | clog2(NWIN) | Pointer value after this edge |
| ovf_trap | output | 1 | Save refused: target window invalid |
| unf_trap | output | 1 | Restore or return refused: target window invalid |
| src_win | output | clog2(NWIN) | Window for source operand reads |
| dst_win | output | clog2(NWIN) | Window for the destination write |

## Verification
The bench builds the block with its defaults: a 32-bit mask and a pending pipeline three deep. It runs mostly at a count of 8 windows, which makes the wrap from 0 to 7 cheap to reach and leaves mask bits above the count to test, and then raises the count to 16 to show that a bit dropped at commit does not come back. The three-deep pipeline places the first move that sees a new mask exactly four cycles after the write, which the bench probes on both sides of that boundary.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  // Kind of window move granted in a cycle, in priority order.
  typedef enum logic [1:0] {
    WREQ_IDLE = 2'd0,
    WREQ_TRAP = 2'd1,
    WREQ_DOWN = 2'd2,
    WREQ_UP   = 2'd3
  } wreq_e;

  function automatic wreq_e pick_req(input logic trap_in,
                                     input logic down_in,
                                     input logic up_a,
                                     input logic up_b);
    if (trap_in)          return WREQ_TRAP;
    else if (down_in)     return WREQ_DOWN;
    else if (up_a | up_b) return WREQ_UP;
    else                  return WREQ_IDLE;
  endfunction

endpackage

// File: rtl/wpc_wrap_step.sv
module wpc_wrap_step #(
  parameter int PTR_W = 5,
  parameter int CNT_W = 6
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] ptr_dn,
  output logic [PTR_W-1:0] ptr_up
);
  localparam int EXT_W = (CNT_W > PTR_W) ? CNT_W : PTR_W;

  logic [EXT_W-1:0] ptr_x;
  logic [EXT_W-1:0] top_x;

  assign ptr_x = EXT_W'(ptr);
  assign top_x = EXT_W'(cnt) - EXT_W'(1);

  // Down: zero (or an out-of-range pointer) wraps to the highest live window.
  always_comb begin
    if (ptr_x == '0 || ptr_x > top_x) ptr_dn = PTR_W'(top_x);
    else                              ptr_dn = ptr - PTR_W'(1);
  end

  // Up: the highest live window (or beyond) wraps to zero.
  always_comb begin
    if (ptr_x >= top_x) ptr_up = '0;
    else                ptr_up = ptr + PTR_W'(1);
  end
endmodule

// File: rtl/wpc_mask_pipe.sv
module wpc_mask_pipe #(
  parameter int NWIN  = 32,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NWIN-1:0] wr_data,
  input  logic [NWIN-1:0] live,
  output logic [NWIN-1:0] mask_q
);
  logic [DEPTH-1:0] stg_vld;
  logic [NWIN-1:0]  stg_dat [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_vld[0] <= 1'b0;
          stg_dat[0] <= '0;
        end else begin
          stg_vld[0] <= wr_en;
          if (wr_en) stg_dat[0] <= wr_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_vld[g] <= 1'b0;
          stg_dat[g] <= '0;
        end else begin
          stg_vld[g] <= stg_vld[g-1];
          if (stg_vld[g-1]) stg_dat[g] <= stg_dat[g-1];
        end
      end
    end
  end

  // Commit: windows beyond the count in force are dropped here.
  always_ff @(posedge clk) begin
    if (!rst_n)                mask_q <= '0;
    else if (stg_vld[DEPTH-1]) mask_q <= stg_dat[DEPTH-1] & live;
  end
endmodule

// File: rtl/wpc_move_arb.sv
module wpc_move_arb #(
  parameter int NWIN  = 32,
  parameter int PTR_W = 5
) (
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             rett_req,
  input  logic             trap_enter,
  input  logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] ptr_dn,
  input  logic [PTR_W-1:0] ptr_up,
  input  logic [NWIN-1:0]  mask,
  output logic [PTR_W-1:0] ptr_nxt,
  output logic             ovf,
  output logic             unf
);
  import wpc_pkg::*;

  wreq_e kind;
  logic  dn_bad;
  logic  up_bad;

  assign kind   = pick_req(trap_enter, save_req, restore_req, rett_req);
  assign dn_bad = mask[ptr_dn];
  assign up_bad = mask[ptr_up];

  always_comb begin
    ptr_nxt = ptr;
    ovf     = 1'b0;
    unf     = 1'b0;
    unique case (kind)
      WREQ_TRAP: ptr_nxt = ptr_dn;
      WREQ_DOWN: begin
        if (dn_bad) ovf     = 1'b1;
        else        ptr_nxt = ptr_dn;
      end
      WREQ_UP: begin
        if (up_bad) unf     = 1'b1;
        else        ptr_nxt = ptr_up;
      end
      default:   ptr_nxt = ptr;
    endcase
  end
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl #(
  parameter  int NWIN       = 32,
  parameter  int PIPE_DEPTH = 3,
  localparam int PTR_W      = $clog2(NWIN),
  localparam int CNT_W      = $clog2(NWIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             rett_req,
  input  logic             trap_enter,
  input  logic             mask_wr,
  input  logic [NWIN-1:0]  mask_wdata,
  input  logic [CNT_W-1:0] win_count,
  output logic [PTR_W-1:0] cwp,
  output logic [PTR_W-1:0] next_cwp,
  output logic             ovf_trap,
  output logic             unf_trap,
  output logic [PTR_W-1:0] src_win,
  output logic [PTR_W-1:0] dst_win
);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NWIN);

  logic [CNT_W-1:0] cnt_eff;
  logic [NWIN-1:0]  live;
  logic [NWIN-1:0]  mask_now;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_dn;
  logic [PTR_W-1:0] ptr_up;
  logic [PTR_W-1:0] ptr_nxt;
  logic             ovf;
  logic             unf;

  always_comb begin
    if (win_count < CNT_MIN)      cnt_eff = CNT_MIN;
    else if (win_count > CNT_MAX) cnt_eff = CNT_MAX;
    else                          cnt_eff = win_count;
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_live
    assign live[i] = (CNT_W'(i) < cnt_eff);
  end

  wpc_mask_pipe #(.NWIN(NWIN), .DEPTH(PIPE_DEPTH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr),
    .wr_data (mask_wdata),
    .live    (live),
    .mask_q  (mask_now)
  );

  wpc_wrap_step #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_step (
    .ptr    (ptr_q),
    .cnt    (cnt_eff),
    .ptr_dn (ptr_dn),
    .ptr_up (ptr_up)
  );

  wpc_move_arb #(.NWIN(NWIN), .PTR_W(PTR_W)) u_arb (
    .save_req    (save_req),
    .restore_req (restore_req),
    .rett_req    (rett_req),
    .trap_enter  (trap_enter),
    .ptr         (ptr_q),
    .ptr_dn      (ptr_dn),
    .ptr_up      (ptr_up),
    .mask        (mask_now),
    .ptr_nxt     (ptr_nxt),
    .ovf         (ovf),
    .unf         (unf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

  assign cwp      = ptr_q;
  assign next_cwp = ptr_nxt;
  assign src_win  = ptr_q;
  assign dst_win  = ptr_nxt;
  assign ovf_trap = ovf;
  assign unf_trap = unf;
endmodule

// File: rtl/wpc_ctrl_chk.sv
module wpc_ctrl_chk #(
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             save_req,
  input logic             restore_req,
  input logic             rett_req,
  input logic             trap_enter,
  input logic [PTR_W-1:0] cwp,
  input logic [PTR_W-1:0] next_cwp,
  input logic             ovf_trap,
  input logic             unf_trap
);
  // R3: a refused save leaves the pointer where it was
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> (cwp == $past(cwp)));

  // R3: overflow only comes from a save without trap entry
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (save_req && !trap_enter));

  // R5: a refused restore or return leaves the pointer where it was
  p_unf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |=> (cwp == $past(cwp)));

  // R5 / R10: underflow only from an upward request that nothing outranks
  p_unf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |-> ((restore_req || rett_req) && !save_req && !trap_enter));

  // R8: trap entry always moves and never flags
  p_trap_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |-> (!ovf_trap && !unf_trap && next_cwp != cwp));

  // R10: never both flags
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_trap && unf_trap));

  // R11: with nothing asked the pointer holds
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_req && !restore_req && !rett_req && !trap_enter) |=> $stable(cwp));
endmodule

bind wpc_ctrl wpc_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_req    (save_req),
  .restore_req (restore_req),
  .rett_req    (rett_req),
  .trap_enter  (trap_enter),
  .cwp         (cwp),
  .next_cwp    (next_cwp),
  .ovf_trap    (ovf_trap),
  .unf_trap    (unf_trap)
);

// File: tb/wpc_ctrl_test.sv
`timescale 1ns/1ps
module wpc_ctrl_test;
  localparam int NWIN  = 32;
  localparam int PTR_W = $clog2(NWIN);
  localparam int CNT_W = $clog2(NWIN + 1);
  localparam real HALF = 2.5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             save_req = 1'b0;
  logic             restore_req = 1'b0;
  logic             rett_req = 1'b0;
  logic             trap_enter = 1'b0;
  logic             mask_wr = 1'b0;
  logic [NWIN-1:0]  mask_wdata = '0;
  logic [CNT_W-1:0] win_count = CNT_W'(8);
  logic [PTR_W-1:0] cwp;
  logic [PTR_W-1:0] next_cwp;
  logic             ovf_trap;
  logic             unf_trap;
  logic [PTR_W-1:0] src_win;
  logic [PTR_W-1:0] dst_win;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic             o_ovf, o_unf;
  logic [PTR_W-1:0] o_src, o_dst, o_nxt;

  always #(HALF) clk = ~clk;

  wpc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .rett_req(rett_req), .trap_enter(trap_enter), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .win_count(win_count), .cwp(cwp),
    .next_cwp(next_cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap),
    .src_win(src_win), .dst_win(dst_win)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One instruction slot: drive at negedge, sample combinational outputs,
  // then let the edge pass and release the inputs.
  task automatic op(input logic sv, input logic rs, input logic rt,
                    input logic te, input logic wr, input logic [NWIN-1:0] d);
    @(negedge clk);
    save_req = sv; restore_req = rs; rett_req = rt; trap_enter = te;
    mask_wr = wr; mask_wdata = d;
    #1;
    o_ovf = ovf_trap; o_unf = unf_trap;
    o_src = src_win;  o_dst = dst_win; o_nxt = next_cwp;
    @(posedge clk);
    #1;
    save_req = 1'b0; restore_req = 1'b0; rett_req = 1'b0; trap_enter = 1'b0;
    mask_wr = 1'b0; mask_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) op(0, 0, 0, 0, 0, '0);
  endtask

  task automatic set_mask(input logic [NWIN-1:0] d);
    op(0, 0, 0, 0, 1, d);
    idle(4);
  endtask

  task automatic t_reset();
    check("R1 cwp after reset", int'(cwp), 0);
    op(1, 0, 0, 0, 0, '0);
    check("R1 no ovf after reset", int'(o_ovf), 0);
    op(0, 1, 0, 0, 0, '0);
    check("R1 no unf after reset", int'(o_unf), 0);
    check("R1 back at 0", int'(cwp), 0);
  endtask

  task automatic t_idle();
    op(0, 0, 0, 0, 0, '0);
    check("R11 flags low", int'(o_ovf | o_unf), 0);
    check("R11 src", int'(o_src), 0);
    check("R11 dst", int'(o_dst), 0);
    check("R11 next", int'(o_nxt), 0);
    check("R11 hold", int'(cwp), 0);
  endtask

  task automatic t_save_restore();
    op(1, 0, 0, 0, 0, '0);
    check("R2 src old", int'(o_src), 0);
    check("R2 dst target", int'(o_dst), 7);
    check("R9 wrap down", int'(cwp), 7);
    op(1, 0, 0, 0, 0, '0);
    check("R2 next", int'(o_nxt), 6);
    check("R2 cwp", int'(cwp), 6);
    op(0, 1, 0, 0, 0, '0);
    check("R4 restore", int'(cwp), 7);
    op(0, 0, 1, 0, 0, '0);
    check("R4 rett dst", int'(o_dst), 0);
    check("R9 wrap up", int'(cwp), 0);
  endtask

  task automatic t_mask_delay();
    op(0, 0, 0, 0, 1, NWIN'(32'h0000_00C0));
    idle(2);
    op(1, 0, 0, 0, 0, '0);
    check("R6 third slot uses old mask", int'(o_ovf), 0);
    check("R6 third slot moved", int'(cwp), 7);
    op(1, 0, 0, 0, 0, '0);
    check("R6 fourth slot uses new mask", int'(o_ovf), 1);
    check("R3 pointer held", int'(cwp), 7);
    check("R3 next held", int'(o_nxt), 7);
    set_mask('0);
    op(0, 1, 0, 0, 0, '0);
    check("R4 back to 0", int'(cwp), 0);
  endtask

  task automatic t_underflow();
    set_mask(NWIN'(32'h0000_0002));
    op(0, 1, 0, 0, 0, '0);
    check("R5 restore flag", int'(o_unf), 1);
    check("R5 restore held", int'(cwp), 0);
    op(0, 0, 1, 0, 0, '0);
    check("R5 rett flag", int'(o_unf), 1);
    check("R5 rett held", int'(cwp), 0);
    set_mask('0);
  endtask

  task automatic t_trap();
    set_mask(NWIN'(32'h0000_00FF));
    op(1, 0, 0, 1, 0, '0);
    check("R8 no ovf on trap", int'(o_ovf), 0);
    check("R8 trap moved", int'(cwp), 7);
    op(0, 0, 0, 1, 0, '0);
    check("R8 trap again", int'(cwp), 6);
    op(1, 0, 0, 0, 0, '0);
    check("R3 save refused", int'(o_ovf), 1);
    check("R3 held at 6", int'(cwp), 6);
    set_mask('0);
    op(0, 1, 0, 0, 0, '0);
    op(0, 1, 0, 0, 0, '0);
    check("R4 returned", int'(cwp), 0);
  endtask

  task automatic t_priority();
    op(1, 1, 1, 0, 0, '0);
    check("R10 save wins", int'(o_dst), 7);
    check("R10 save moved", int'(cwp), 7);
    op(0, 1, 1, 0, 0, '0);
    check("R10 up move", int'(cwp), 0);
    set_mask(NWIN'(32'h0000_0082));
    op(1, 1, 0, 0, 0, '0);
    check("R10 only ovf", int'({o_ovf, o_unf}), 2);
    set_mask('0);
  endtask

  task automatic t_count();
    set_mask(NWIN'(32'h0000_1000));
    win_count = CNT_W'(16);
    for (int k = 0; k < 4; k++) op(1, 0, 0, 0, 0, '0);
    check("R7 dropped bit stays zero", int'(o_ovf), 0);
    check("R7 reached 12", int'(cwp), 12);
    set_mask(NWIN'(32'h0000_1000));
    op(0, 1, 0, 0, 0, '0);
    check("R7 moved to 13", int'(cwp), 13);
    op(1, 0, 0, 0, 0, '0);
    check("R7 live bit traps", int'(o_ovf), 1);
    set_mask('0);
    for (int k = 0; k < 3; k++) op(0, 1, 0, 0, 0, '0);
    check("R9 wrap at 16", int'(cwp), 0);
    win_count = CNT_W'(0);
    op(1, 0, 0, 0, 0, '0);
    check("R9 count clamps to 2", int'(cwp), 1);
    op(0, 1, 0, 0, 0, '0);
    check("R9 clamp wrap up", int'(cwp), 0);
    win_count = CNT_W'(8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_idle();
    t_save_restore();
    t_mask_delay();
    t_underflow();
    t_trap();
    t_priority();
    t_count();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule